// File: doc/BRIEF.md
# Two-Band Zero-Crossing and Amplitude Feature Sampler

This block turns the digital comparator outputs of a two-band speech front end into per-window features for recognition software. Each band supplies one zero-crossing comparator bit and three amplitude comparator bits. The zero-crossing bit reads 1 while the filtered signal is below the reference and 0 while it is above. The lowest amplitude bit sits just above the no-signal level. The other two sit at roughly one third and two thirds of full scale. All comparator bits are asynchronous to the block clock, so each one first passes through a two-flop synchroniser.

Time is divided into fixed windows of `WIN_CYCLES` clock cycles. Within a window, each band counts every change of its synchronised zero-crossing bit, whether the bit rises or falls. A pure tone therefore produces a count of twice its frequency times the window length. The counter saturates rather than wrapping. At the last cycle of the window, the block latches each band's count and a 2-bit amplitude level code. It then raises `feat_valid` for one cycle and restarts the counters from zero.

A word-tracking state machine has three states: `ST_SILENT`, `ST_SPEECH` and `ST_HANGOVER`. It follows the lowest amplitude bit of both bands:
- `T_START` (SILENT to SPEECH): either band's lowest bit is set.
- `T_FADE` (SPEECH to HANGOVER): both lowest bits are clear.
- `T_RESUME` (HANGOVER to SPEECH): a lowest bit returns.
- `T_END` (HANGOVER to SILENT): the window ends and the number of quiet window ends has reached `hang_windows`.

Otherwise each state holds. `word_active` is high in SPEECH and HANGOVER.

Top module: `zc_feature_sampler`

## Requirements
- R1: Each band counts every change of its zero-crossing bit `zc_in[b]`, both 0 to 1 and 1 to 0, and reports the number of changes seen in a window on `count_out[b*CNT_W +: CNT_W]`.
- R2: A band count that would exceed 2^CNT_W-1 in one window is reported as 2^CNT_W-1.
- R3: `feat_valid` is a one-cycle pulse repeating every `WIN_CYCLES` cycles. `count_out` and `level_out` change only on the cycle `feat_valid` is high, and hold their values between pulses.
- R4: The count starts from zero in each window: a window's report does not include changes from earlier windows.
- R5: `level_out[b*2 +: 2]` is the code of the highest asserted amplitude bit of band b at the window end. The amplitude bits are `amp_in[3*b+0]` (lowest), `amp_in[3*b+1]` and `amp_in[3*b+2]`. Bit 2 gives 3, else bit 1 gives 2, else bit 0 gives 1, else 0. This holds even for non-monotonic patterns.
- R6: From silence, `word_active` rises on the third rising clock edge after either band's lowest amplitude bit is asserted. The delay is two synchroniser stages plus the state register.
- R7: After both lowest bits clear, `word_active` stays high until the `hang_windows`-th window end that follows. It falls on the same edge that raises `feat_valid`. A `hang_windows` of 0 behaves as 1.
- R8: If a lowest bit returns during the hangover, the block goes back to speech and restarts the quiet-window count.
- R9: While `rst_n` is low, all outputs are 0.
- R10: The upper two amplitude bits affect only the level code. Without the lowest bit, they neither start a word nor hold one active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| hang_windows | input | HANG_W | Quiet window ends needed to end a word |
| zc_in | input | NUM_BANDS | Zero-crossing comparator bit per band (asynchronous) |
| amp_in | input | 3*NUM_BANDS | Amplitude comparator bits, three per band, lowest first (asynchronous) |
| count_out | output | NUM_BANDS*CNT_W | Latched transition count per band |
| level_out | output | 2*NUM_BANDS | Latched amplitude level code per band |
| word_active | output | 1 | High while a word is in progress or in hangover |
| feat_valid | output | 1 | One-cycle pulse when new features are latched |

## Verification
The bench drives bursts of toggles long enough to overflow the counter. It follows each burst with a window of one or zero toggles. A counter that wrapped would report a small number. One that failed to clear would carry the previous window's count forward. It applies non-monotonic amplitude patterns and patterns with only upper bits set. A plain bit-count encoder, or word detection that ORs all three bits, would misreport these.

The word sequences interrupt a hangover and then let it run out. The bench also changes `hang_windows` to 0 and to larger values. This exposes an off-by-one end window, a quiet count that is not restarted, or a word that never ends. The start latency is sampled on the exact cycle. A missing or extra synchroniser stage shows up as an early or late rise.

// File: rtl/zcf_pkg.sv
package zcf_pkg;

    typedef enum logic [1:0] {
        ST_SILENT   = 2'd0,
        ST_SPEECH   = 2'd1,
        ST_HANGOVER = 2'd2
    } word_state_e;

    localparam int AMP_BITS = 3;
    localparam int LEVEL_W  = 2;

    // Highest asserted threshold wins, whatever the pattern below it.
    function automatic logic [LEVEL_W-1:0] amp_to_level(input logic [AMP_BITS-1:0] a);
        logic [LEVEL_W-1:0] lvl;
        lvl = 2'd0;
        for (int k = 0; k < AMP_BITS; k++) begin
            if (a[k]) lvl = LEVEL_W'(k + 1);
        end
        return lvl;
    endfunction

endpackage

// File: rtl/zcf_sync.sv
module zcf_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/zcf_window.sv
module zcf_window #(
    parameter int WIN_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);

    localparam int WCW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WCW-1:0] LAST = WCW'(WIN_CYCLES - 1);

    logic [WCW-1:0] wcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (wcnt_q == LAST) begin
            wcnt_q <= '0;
        end else begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assign win_end = (wcnt_q == LAST);

endmodule

// File: rtl/zcf_band.sv
module zcf_band
    import zcf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                zc_s,
    input  logic [AMP_BITS-1:0] amp_s,
    input  logic                win_end,
    output logic [CNT_W-1:0]    count_q,
    output logic [LEVEL_W-1:0]  level_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             zc_prev_q;
    logic             crossing;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    assign crossing = zc_s ^ zc_prev_q;

    always_comb begin
        cnt_next = cnt_q;
        if (crossing && (cnt_q != CNT_MAX)) cnt_next = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_prev_q <= 1'b0;
            cnt_q     <= '0;
            count_q   <= '0;
            level_q   <= '0;
        end else begin
            zc_prev_q <= zc_s;
            if (win_end) begin
                count_q <= cnt_next;
                level_q <= amp_to_level(amp_s);
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_next;
            end
        end
    end

endmodule

// File: rtl/zcf_word_fsm.sv
module zcf_word_fsm
    import zcf_pkg::*;
#(
    parameter int HANG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_low,
    input  logic              win_end,
    input  logic [HANG_W-1:0] hang_windows,
    output logic              word_active
);

    word_state_e       state_q, state_d;
    logic [HANG_W-1:0] quiet_q, quiet_d;
    logic              quiet_done;

    assign quiet_done = ({1'b0, quiet_q} + 1'b1) >= {1'b0, hang_windows};

    always_comb begin
        state_d = state_q;
        quiet_d = quiet_q;
        unique case (state_q)
            ST_SILENT: begin
                if (any_low) state_d = ST_SPEECH;            // T_START
            end
            ST_SPEECH: begin
                if (!any_low) begin
                    state_d = ST_HANGOVER;                   // T_FADE
                    quiet_d = '0;
                end
            end
            ST_HANGOVER: begin
                if (any_low) begin
                    state_d = ST_SPEECH;                     // T_RESUME
                    quiet_d = '0;
                end else if (win_end) begin
                    if (quiet_done) state_d = ST_SILENT;     // T_END
                    else            quiet_d = quiet_q + 1'b1;
                end
            end
            default: state_d = ST_SILENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SILENT;
            quiet_q <= '0;
        end else begin
            state_q <= state_d;
            quiet_q <= quiet_d;
        end
    end

    always_comb begin
        word_active = (state_q != ST_SILENT);
    end

endmodule

// File: rtl/zc_feature_sampler.sv
module zc_feature_sampler
    import zcf_pkg::*;
#(
    parameter int NUM_BANDS  = 2,
    parameter int CNT_W      = 8,
    parameter int WIN_CYCLES = 1000,
    parameter int HANG_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [HANG_W-1:0]              hang_windows,
    input  logic [NUM_BANDS-1:0]           zc_in,
    input  logic [NUM_BANDS*AMP_BITS-1:0]  amp_in,
    output logic [NUM_BANDS*CNT_W-1:0]     count_out,
    output logic [NUM_BANDS*LEVEL_W-1:0]   level_out,
    output logic                           word_active,
    output logic                           feat_valid
);

    localparam int RAW_W = NUM_BANDS * (1 + AMP_BITS);

    logic [RAW_W-1:0]              raw_bits;
    logic [RAW_W-1:0]              sync_bits;
    logic [NUM_BANDS-1:0]          zc_s;
    logic [NUM_BANDS*AMP_BITS-1:0] amp_s;
    logic [NUM_BANDS-1:0]          low_s;
    logic                          win_end;
    logic                          valid_q;

    assign raw_bits = {amp_in, zc_in};

    zcf_sync #(.WIDTH(RAW_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bits),
        .sync_out (sync_bits)
    );

    assign zc_s  = sync_bits[NUM_BANDS-1:0];
    assign amp_s = sync_bits[RAW_W-1:NUM_BANDS];

    zcf_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        assign low_s[b] = amp_s[b*AMP_BITS];
        zcf_band #(.CNT_W(CNT_W)) u_band (
            .clk     (clk),
            .rst_n   (rst_n),
            .zc_s    (zc_s[b]),
            .amp_s   (amp_s[b*AMP_BITS +: AMP_BITS]),
            .win_end (win_end),
            .count_q (count_out[b*CNT_W +: CNT_W]),
            .level_q (level_out[b*LEVEL_W +: LEVEL_W])
        );
    end

    zcf_word_fsm #(.HANG_W(HANG_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_low      (|low_s),
        .win_end      (win_end),
        .hang_windows (hang_windows),
        .word_active  (word_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= win_end;
    end

    assign feat_valid = valid_q;

endmodule

// File: rtl/zcf_checker.sv
module zcf_checker #(
    parameter int NUM_BANDS  = 2,
    parameter int CNT_W      = 8,
    parameter int WIN_CYCLES = 1000,
    parameter int HANG_W     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_BANDS*3-1:0]       amp_in,
    input logic [NUM_BANDS*CNT_W-1:0]   count_out,
    input logic [NUM_BANDS*2-1:0]       level_out,
    input logic                         word_active,
    input logic                         feat_valid
);

    int   gap_q;
    logic seen_q;
    logic raw_low;

    always_comb begin
        raw_low = 1'b0;
        for (int b = 0; b < NUM_BANDS; b++) raw_low = raw_low | amp_in[b*3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (feat_valid) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1;
        end
    end

    AST_VALID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_valid && seen_q) |-> (gap_q == WIN_CYCLES - 1));          // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        feat_valid |=> !feat_valid);                                      // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_valid |-> $stable(count_out));                              // R3
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_valid |-> $stable(level_out));                              // R5
    AST_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_active) |-> $past(raw_low, 3));                        // R6
    AST_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_active) |-> feat_valid);                               // R7

endmodule

bind zc_feature_sampler zcf_checker #(
    .NUM_BANDS  (NUM_BANDS),
    .CNT_W      (CNT_W),
    .WIN_CYCLES (WIN_CYCLES),
    .HANG_W     (HANG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .amp_in      (amp_in),
    .count_out   (count_out),
    .level_out   (level_out),
    .word_active (word_active),
    .feat_valid  (feat_valid)
);

// File: tb/sim_zc_feature_sampler.sv
module sim_zc_feature_sampler;

    localparam int NB  = 2;
    localparam int CW  = 4;
    localparam int WIN = 64;
    localparam int HW  = 4;
    localparam int NWIN = 60;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [HW-1:0]   hang = 4'd2;
    logic [NB-1:0]   zc = '0;
    logic [NB*3-1:0] amp = '0;
    logic [NB*CW-1:0] cnt_o;
    logic [NB*2-1:0] lvl_o;
    logic            wa;
    logic            fv;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    zc_feature_sampler #(.NUM_BANDS(NB), .CNT_W(CW), .WIN_CYCLES(WIN), .HANG_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .hang_windows(hang), .zc_in(zc), .amp_in(amp),
        .count_out(cnt_o), .level_out(lvl_o), .word_active(wa), .feat_valid(fv));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_level(input logic [2:0] a);
        if (a[2]) return 3;
        if (a[1]) return 2;
        if (a[0]) return 1;
        return 0;
    endfunction

    function automatic int sat(input int n);
        return (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
    endfunction

    task automatic wait_valid(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!fv && cycles < 4 * WIN);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        int tog [NB];
        logic [2:0] apat [NB];
        bit model_active;
        int quiet;
        bit low;
        void'($urandom(32'h5eed_0042));
        model_active = 0;
        quiet = 0;

        repeat (4) @(negedge clk);
        chk("R9 count", int'(cnt_o), 0);
        chk("R9 level", int'(lvl_o), 0);
        chk("R9 word_active", int'(wa), 0);
        chk("R9 feat_valid", int'(fv), 0);
        rst_n = 1'b1;

        wait_valid(cyc);
        for (int w = 0; w < NWIN; w++) begin
            // pattern choice: directed first, random after
            for (int b = 0; b < NB; b++) begin
                tog[b]  = $urandom_range(0, 24);
                apat[b] = 3'($urandom_range(0, 7));
            end
            case (w)
                0: begin tog[0] = 24; tog[1] = 16; apat[0] = 3'b100; apat[1] = 3'b000; end
                1: begin tog[0] = 1;  tog[1] = 0;  apat[0] = 3'b000; apat[1] = 3'b000; end
                2: begin tog[0] = 15; tog[1] = 2;  apat[0] = 3'b001; apat[1] = 3'b010; end
                3, 4: begin apat[0] = 3'b110; apat[1] = 3'b000; end
                5: begin apat[0] = 3'b000; apat[1] = 3'b101; end
                6: begin apat[0] = 3'b000; apat[1] = 3'b010; end
                7, 8: begin apat[0] = 3'b000; apat[1] = 3'b000; end
                default: ;
            endcase
            if (w == 20) hang = 4'd0;
            if (w == 35) hang = 4'd3;
            if (w == 48) hang = 4'd1;
            if (w >= 36 && w <= 39) begin apat[0][0] = 1'b0; apat[1][0] = 1'b0; end
            if (w == 40) apat[1][0] = 1'b1;

            // apply amplitude bits just after the window boundary
            @(negedge clk);
            chk("R3 valid one cycle", int'(fv), 0);
            for (int b = 0; b < NB; b++) amp[b*3 +: 3] = apat[b];
            low = apat[0][0] | apat[1][0];
            @(negedge clk);
            @(negedge clk);
            if (!model_active) chk("R6 not yet active", int'(wa), 0);
            @(negedge clk);
            chk("R6 word_active after three edges", int'(wa), int'(model_active | low));

            for (int s = 0; s < 24; s++) begin
                for (int b = 0; b < NB; b++) if (s < tog[b]) zc[b] = ~zc[b];
                @(negedge clk);
                @(negedge clk);
            end

            wait_valid(cyc);
            chk("R3 window period", cyc + 52, WIN);

            if (low) begin
                model_active = 1;
                quiet = 0;
            end else if (model_active) begin
                quiet++;
                if (quiet >= int'(hang)) model_active = 0;
            end

            for (int b = 0; b < NB; b++) begin
                chk((w == 1) ? "R4 count after saturation" : "R1 R2 count",
                    int'(cnt_o[b*CW +: CW]), sat(tog[b]));
                chk("R5 level code", int'(lvl_o[b*2 +: 2]), exp_level(apat[b]));
            end
            chk((w >= 3 && w <= 8) ? "R10 R8 R7 word_active" : "R7 R8 word_active",
                int'(wa), int'(model_active));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule